// File: doc/BRIEF.md
# Chained PWM Stage Run and Prescale Controller

This block governs one stage of a chain of three pulse-width generators. An 8-bit control word sets the input clock division, starts and stops the stage, and lets it follow the stage before it in the chain. It also sets how a stop request is handled and whether flank width modulation covers both on-time phases. The block produces a prescaled count enable (`cnt_en`) and a registered effective run signal (`run_active`).

A small up-down on-time counter runs from the count enable. It shows the waveform phase and flags the end of each period. A deferred halt waits for that flag. Two fault-override enable bits are passed straight through to the output stage, which lies outside this block.

A stage can run for two reasons. Its own run bit may be set, or, in slave mode, it follows the upstream stage. That upstream stage counts as running when its own run bit is set, or when its autorun bit and the root stage's run bit are both set.

Top module: `pwm_stage_ctrl`

## Requirements
- R1: After reset, every control bit is zero, and `run_active`, `cnt_en`, `cycle_end`, `flank_mod_act`, both override outputs and `ontime_cnt` are all zero.
- R2: While running, `cnt_en` pulses once every N clocks. N is set by control bits 7:6: 00 gives N=1, 01 gives N=4, 10 gives N=32 and 11 gives N=256.
- R3: The prescaler is held cleared while `run_active` is low. The first `cnt_en` therefore appears on the N-th clock on which `run_active` is high.
- R4: Control bit 0 (local run) starts the stage one clock after the control word is loaded. It keeps the stage running whatever the chain inputs are, including when bit 2 (autorun) is also set.
- R5: With bit 0 clear and bit 2 set, the stage runs exactly when `up_run` is high, or when `up_chain` and `root_run` are both high. With bit 2 clear, the chain inputs have no effect.
- R6: A run request is removed when bit 0 and the chain request both go away. If bit 1 (complete cycle) is clear at that point, `run_active` falls on the next clock.
- R7: If bit 1 is set and bit 2 is clear when the run request is removed, `run_active` stays high until the `cycle_end` pulse. It falls on the clock after that pulse, with `ontime_cnt` at zero.
- R8: In slave mode (bit 2 set), bit 1 has no effect. When the chain request drops, `run_active` falls on the next clock.
- R9: On each `cnt_en`, `ontime_cnt` counts up from 0 to PERIOD_TOP and then back down to 0. One period lasts 2*PERIOD_TOP enables. `cycle_end` is a one-clock pulse on the enable that returns the count to 0. The counter is zero whenever the stage is stopped.
- R10: `flank_mod_act` is high while running in the down phase (on-time 1), which starts at the PERIOD_TOP count. When bit 5 (balance) is set, it is also high in the up phase (on-time 0).
- R11: `fault_ovr_a` follows control bit 3 and `fault_ovr_b` follows control bit 4 from the clock after the control word is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Load strobe for the control word |
| ctrl_wdata | input | 8 | Control word value |
| up_run | input | 1 | Run bit of the upstream stage |
| up_chain | input | 1 | Autorun bit of the upstream stage |
| root_run | input | 1 | Run bit of the root stage |
| cnt_en | output | 1 | Prescaled count enable |
| run_active | output | 1 | Effective run state |
| ontime_cnt | output | CNT_W | Up-down on-time count |
| cycle_end | output | 1 | One-clock pulse at the end of a period |
| flank_mod_act | output | 1 | Flank width modulation applies in the current phase |
| fault_ovr_a | output | 1 | Direct fault override enable, output pair A |
| fault_ovr_b | output | 1 | Direct fault override enable, output pair B |

## Verification
A corrupted run flag is visible on `run_active` one clock after the request changes. A wrong prescaler count moves the first `cnt_en` and the spacing between enables, so the error is exposed within one division period. A bad on-time count or direction shows on `ontime_cnt` and `flank_mod_act` at the next enable, and it also shifts `cycle_end`. That shift in turn moves the moment a deferred halt completes by whole enables.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;

   // Control word layout; bit positions follow the decode used by neighbours
   typedef struct packed {
      logic [1:0] pre_sel;    // 7:6 clock division select
      logic       bal_fm;     // 5   modulate both on-time phases
      logic       ovr_b;      // 4   direct fault override, pair B
      logic       ovr_a;      // 3   direct fault override, pair A
      logic       chain_run;  // 2   follow upstream stage
      logic       full_cyc;   // 1   finish period before halting
      logic       run_req;    // 0   local run
   } stage_ctrl_t;

   function automatic int unsigned div_ratio(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 32;
         default: return 256;
      endcase
   endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_stage_pkg::*;
#(
   parameter int unsigned PRE_W = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic [1:0] sel_i,
   output logic       tick_o
);
   localparam int unsigned MAX_DIV = 256;

   generate
      if (PRE_W < $clog2(MAX_DIV)) begin : g_bad_width
         $error("PRE_W too narrow for largest division");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] limit;

   assign limit  = PRE_W'(div_ratio(sel_i) - 1);
   assign tick_o = run_i && (pre_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run_i || tick_o) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   // R3: a stopped stage leaves the divider cleared
   p_pre_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (pre_q == '0));

endmodule

// File: rtl/pwm_run_ctrl.sv
module pwm_run_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic run_bit_i,
   input  logic chain_bit_i,
   input  logic full_cyc_i,
   input  logic up_run_i,
   input  logic up_chain_i,
   input  logic root_run_i,
   input  logic cycle_end_i,
   output logic running_o
);
   logic upstream_live;
   logic req;
   logic defer;
   logic running_q;

   assign upstream_live = up_run_i | (up_chain_i & root_run_i);
   // local run bit wins over the chain request
   assign req   = run_bit_i | (chain_bit_i & upstream_live);
   // deferred stop only outside slave mode
   assign defer = full_cyc_i & ~chain_bit_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q <= 1'b0;
      end else if (req) begin
         running_q <= 1'b1;
      end else if (running_q && defer && !cycle_end_i) begin
         running_q <= 1'b1;
      end else begin
         running_q <= 1'b0;
      end
   end

   assign running_o = running_q;

   p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run_bit_i |=> running_q);

   p_stop_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && !req && !defer) |=> !running_q);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && !req && defer && !cycle_end_i) |=> running_q);

   p_end_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && !req && defer && cycle_end_i) |=> !running_q);

endmodule

// File: rtl/pwm_ontime_cnt.sv
module pwm_ontime_cnt #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned TOP   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             bal_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             cycle_end_o,
   output logic             flank_o
);
   localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(TOP);
   localparam logic [CNT_W-1:0] NEAR_V = CNT_W'(TOP - 1);
   localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

   generate
      if (TOP < 2) begin : g_bad_top
         $error("TOP must be at least 2");
      end
      if (TOP >= (64'd1 << CNT_W)) begin : g_bad_cnt_w
         $error("CNT_W too narrow for TOP");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             down_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         cnt_q  <= '0;
         down_q <= 1'b0;
      end else if (tick_i) begin
         if (!down_q) begin
            if (cnt_q == NEAR_V) begin
               cnt_q  <= TOP_V;
               down_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            if (cnt_q == ONE_V) begin
               cnt_q  <= '0;
               down_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign cnt_o       = cnt_q;
   assign cycle_end_o = run_i && tick_i && down_q && (cnt_q == ONE_V);
   assign flank_o     = run_i && (down_q || bal_i);

   p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TOP_V);

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));

   p_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end_o |=> !cycle_end_o);

endmodule

// File: rtl/pwm_stage_ctrl.sv
module pwm_stage_ctrl
   import pwm_stage_pkg::*;
#(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned PERIOD_TOP = 5,
   parameter int unsigned PRE_W      = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic [7:0]       ctrl_wdata,
   input  logic             up_run,
   input  logic             up_chain,
   input  logic             root_run,
   output logic             cnt_en,
   output logic             run_active,
   output logic [CNT_W-1:0] ontime_cnt,
   output logic             cycle_end,
   output logic             flank_mod_act,
   output logic             fault_ovr_a,
   output logic             fault_ovr_b
);
   stage_ctrl_t ctrl_q;
   logic        running;
   logic        tick;
   logic        end_pulse;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q <= stage_ctrl_t'(ctrl_wdata);
      end
   end

   pwm_run_ctrl i_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_bit_i   (ctrl_q.run_req),
      .chain_bit_i (ctrl_q.chain_run),
      .full_cyc_i  (ctrl_q.full_cyc),
      .up_run_i    (up_run),
      .up_chain_i  (up_chain),
      .root_run_i  (root_run),
      .cycle_end_i (end_pulse),
      .running_o   (running)
   );

   pwm_prescaler #(.PRE_W(PRE_W)) i_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (running),
      .sel_i  (ctrl_q.pre_sel),
      .tick_o (tick)
   );

   pwm_ontime_cnt #(.CNT_W(CNT_W), .TOP(PERIOD_TOP)) i_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (running),
      .tick_i      (tick),
      .bal_i       (ctrl_q.bal_fm),
      .cnt_o       (ontime_cnt),
      .cycle_end_o (end_pulse),
      .flank_o     (flank_mod_act)
   );

   assign cnt_en      = tick;
   assign run_active  = running;
   assign cycle_end   = end_pulse;
   assign fault_ovr_a = ctrl_q.ovr_a;
   assign fault_ovr_b = ctrl_q.ovr_b;

   p_ovr_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> ((fault_ovr_a == $past(ctrl_wdata[3])) &&
                   (fault_ovr_b == $past(ctrl_wdata[4]))));

   p_en_when_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |-> run_active);

endmodule

// File: tb/test_pwm_stage_ctrl.sv
module test_pwm_stage_ctrl;
   localparam int TOP = 5;
   localparam int PER = 2 * TOP;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [7:0] ctrl_wdata = 8'h00;
   logic       up_run = 1'b0;
   logic       up_chain = 1'b0;
   logic       root_run = 1'b0;
   logic       cnt_en, run_active, cycle_end, flank_mod_act, fault_ovr_a, fault_ovr_b;
   logic [7:0] ontime_cnt;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   pwm_stage_ctrl #(.CNT_W(8), .PERIOD_TOP(TOP), .PRE_W(9)) i_pwm_stage_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .up_run(up_run), .up_chain(up_chain), .root_run(root_run),
      .cnt_en(cnt_en), .run_active(run_active), .ontime_cnt(ontime_cnt),
      .cycle_end(cycle_end), .flank_mod_act(flank_mod_act),
      .fault_ovr_a(fault_ovr_a), .fault_ovr_b(fault_ovr_b)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int div_of(input int s);
      case (s)
         0: return 1;
         1: return 4;
         2: return 32;
         default: return 256;
      endcase
   endfunction

   function automatic logic [7:0] mk(input int pre, input bit bal, input bit ob,
                                     input bit oa, input bit ch, input bit fc, input bit rn);
      return {pre[1:0], bal, ob, oa, ch, fc, rn};
   endfunction

   function automatic bit exp_run(input bit rn, input bit ch, input bit ur, input bit uc, input bit rr);
      return rn | (ch & (ur | (uc & rr)));
   endfunction

   function automatic int exp_cnt(input int k);
      int m = k % PER;
      return (m <= TOP) ? m : PER - m;
   endfunction

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      ctrl_we = 1'b1;
      ctrl_wdata = d;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'h5eed_1234));
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 run_active", int'(run_active), 0);
      chk("R1 cnt_en", int'(cnt_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ontime", int'(ontime_cnt), 0);
      chk("R1 ovr", int'({fault_ovr_b, fault_ovr_a}), 0);
      chk("R1 end/flank", int'({cycle_end, flank_mod_act}), 0);

      // R9 / R10 waveform at division 1, single-sided modulation
      wr(mk(0, 0, 0, 0, 0, 0, 1));
      for (int k = 0; k < 2 * PER + 2; k++) begin
         @(negedge clk);
         chk("R4 run", int'(run_active), 1);
         chk("R9 count", int'(ontime_cnt), exp_cnt(k));
         chk("R9 cycle_end", int'(cycle_end), int'((k % PER) == PER - 1));
         chk("R10 flank", int'(flank_mod_act), int'((k % PER) >= TOP));
      end
      // R10 balanced modulation covers both phases
      wr(mk(0, 1, 0, 0, 0, 0, 1));
      for (int k = 0; k < PER; k++) begin
         @(negedge clk);
         chk("R10 balanced flank", int'(flank_mod_act), 1);
      end

      // R6 immediate halt
      wr(mk(0, 0, 0, 0, 0, 0, 0));
      @(negedge clk);
      chk("R6 halt", int'(run_active), 0);
      @(negedge clk);
      chk("R9 idle count", int'(ontime_cnt), 0);
      chk("R6 no enable", int'(cnt_en), 0);

      // R7 deferred halt
      wr(mk(0, 0, 0, 0, 0, 1, 1));
      repeat (3) @(negedge clk);
      wr(mk(0, 0, 0, 0, 0, 1, 0));
      n = 0;
      while (!cycle_end && n < 50) begin
         chk("R7 still running", int'(run_active), 1);
         @(negedge clk);
         n++;
      end
      chk("R7 wait to end", n, 5);
      @(negedge clk);
      chk("R7 halted", int'(run_active), 0);
      chk("R7 count zero", int'(ontime_cnt), 0);

      // R5 / R8 slave mode ignores complete-cycle
      @(negedge clk);
      up_run = 1'b1;
      wr(mk(0, 0, 0, 0, 1, 1, 0));
      @(negedge clk);
      chk("R5 follow upstream", int'(run_active), 1);
      repeat (3) @(negedge clk);
      up_run = 1'b0;
      @(negedge clk);
      chk("R8 slave immediate halt", int'(run_active), 0);

      // R4 local run bit prevails over autorun
      wr(mk(0, 0, 0, 0, 1, 0, 1));
      @(negedge clk);
      chk("R4 run with chain off", int'(run_active), 1);
      up_run = 1'b1;
      @(negedge clk);
      up_run = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R4 run after chain drop", int'(run_active), 1);

      // R2 / R3 prescale ratios, each restarted from a stop
      for (int s = 0; s < 4; s++) begin
         wr(mk(0, 0, 0, 0, 0, 0, 0));
         @(negedge clk);
         chk("R6 stopped before restart", int'(run_active), 0);
         wr(mk(s, 0, 0, 0, 0, 0, 1));
         @(negedge clk);
         chk("R4 started", int'(run_active), 1);
         n = 1;
         while (!cnt_en && n < 600) begin
            @(negedge clk);
            n++;
         end
         chk("R3 first enable", n, div_of(s));
         n = 0;
         do begin
            @(negedge clk);
            n++;
         end while (!cnt_en && n < 600);
         chk("R2 enable spacing", n, div_of(s));
      end
      wr(mk(0, 0, 0, 0, 0, 0, 0));
      @(negedge clk);

      // R5 directed: autorun and root alone do not start
      up_run = 1'b0; up_chain = 1'b1; root_run = 1'b0;
      wr(mk(0, 0, 0, 0, 1, 0, 0));
      @(negedge clk);
      chk("R5 upstream autorun only", int'(run_active), 0);
      up_chain = 1'b0; root_run = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R5 root only", int'(run_active), 0);

      // R5 / R11 random mix
      for (int i = 0; i < 40; i++) begin
         bit ur, uc, rr, ch, oa, ob;
         ur = 1'($urandom); uc = 1'($urandom); rr = 1'($urandom);
         ch = 1'($urandom); oa = 1'($urandom); ob = 1'($urandom);
         @(negedge clk);
         up_run = ur; up_chain = uc; root_run = rr;
         wr(mk(0, 0, ob, oa, ch, 0, 0));
         @(negedge clk);
         chk("R5 chained run", int'(run_active), int'(exp_run(1'b0, ch, ur, uc, rr)));
         chk("R11 override A", int'(fault_ovr_a), int'(oa));
         chk("R11 override B", int'(fault_ovr_b), int'(ob));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule